// File: doc/BRIEF.md
# Rotating Multi-Plane Cell Distributor

This block sits between one linecard and a stack of identical switch planes. Cells arrive one at a time from the linecard. Each cell is handed, whole and unsplit, to exactly one plane. The chosen plane advances by one for every accepted cell and wraps after the last plane. A plane that has taken a cell is busy carrying it for several cell times. It signals this through its ready line. If the plane next in the rotation is not ready, the input stalls. The block never skips ahead to another plane, so cell order across planes stays fixed.

Each plane also has its own slow scheduler stage. A free-running cell-time counter steps once per cell-time tick and wraps at the number of planes. On a tick where the counter equals a plane's index, that plane copies its supplied crossbar configuration into a holding register. It then keeps that configuration for one full frame of ticks. The load instants are therefore spread evenly across the planes. The crossbar itself and the matching algorithm lie outside this block.

Top module: `cell_plane_distributor`

## Requirements
- R1: While reset is asserted and right after it, every plane_valid bit is 0 and every held plane configuration is all zeros, meaning idle. The first accepted cell goes to plane 0. The first tick after reset strobes the configuration load of plane 0.
- R2: A cell accepted on a clock edge (cell_valid and cell_ready both high) appears on exactly one plane one clock later. On that cycle the plane's plane_valid bit is high and its slice of plane_data equals the accepted cell_data. At no time is more than one plane_valid bit high.
- R3: Accepted cells go to planes in the order 0, 1, …, NPLANES-1, then back to 0. The target advances only when a cell is accepted.
- R4: cell_ready equals the plane_ready bit of the current target plane. While that bit is low, no cell is taken and no plane_valid rises, even if other planes are ready. The target plane does not change during the stall.
- R5: The cell-time counter starts at 0 after reset, advances by one on each cycle with cell_tick high, and wraps from NPLANES-1 to 0.
- R6: sched_load[i] is high only in a cycle where cell_tick is high and the cell-time counter equals i. At most one sched_load bit is high at a time.
- R7: One clock after sched_load[i] is high, slice i of sched_cfg equals slice i of sched_cfg_in as it was in the strobe cycle. Slice i of sched_cfg changes at no other time, so it is held for NPLANES ticks.
- R8: Changes on sched_cfg_in in cycles without a load strobe for a plane have no effect on that plane's held configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_tick | input | 1 | One-cycle pulse marking each cell time |
| cell_valid | input | 1 | Incoming cell present |
| cell_data | input | CELL_W | Incoming cell contents |
| cell_ready | output | 1 | Current target plane can take the cell |
| plane_ready | input | NPLANES | Per-plane ready to accept a cell |
| plane_valid | output | NPLANES | Per-plane one-cycle cell-delivery pulse |
| plane_data | output | NPLANES*CELL_W | Per-plane cell contents, plane i at slice i |
| sched_cfg_in | input | NPLANES*CFG_W | Supplied crossbar configuration per plane, slice i |
| sched_load | output | NPLANES | Per-plane configuration load strobe |
| sched_cfg | output | NPLANES*CFG_W | Held crossbar configuration per plane, slice i |

## Verification
Delivery happens one clock after acceptance. The driver applies a cell at a falling edge and pushes the expected plane and data into a queue. The monitor compares at the next falling edge, where the registered plane_valid is visible.

The load strobe is combinational from cell_tick and the counter. It is checked in the same half-cycle in which the tick is driven. The held configuration is checked at the following falling edge, one register later.

Stall behaviour is checked over several falling edges while the target plane is held not ready. During that window, cell_ready must stay low and no delivery may appear.

// File: rtl/cpd_pkg.sv
package cpd_pkg;
  localparam int unsigned CPD_DEF_PLANES = 4;
  localparam int unsigned CPD_DEF_CELL_W = 32;
  localparam int unsigned CPD_DEF_CFG_W  = 16;

  function automatic int unsigned cpd_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cpd_mod_counter.sv
module cpd_mod_counter #(
  parameter int unsigned LIMIT = 4,
  parameter int unsigned W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (adv) begin
      count_d = (count_q == LAST) ? '0 : count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/cpd_plane_lane.sv
module cpd_plane_lane #(
  parameter int unsigned CELL_W = 32,
  parameter int unsigned CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CELL_W-1:0] cell_in,
  input  logic              load,
  input  logic [CFG_W-1:0]  cfg_nxt,
  output logic              valid_o,
  output logic [CELL_W-1:0] data_o,
  output logic [CFG_W-1:0]  cfg_o
);
  logic              valid_q, valid_d;
  logic [CELL_W-1:0] data_q, data_d;
  logic [CFG_W-1:0]  cfg_q, cfg_d;

  always_comb begin
    valid_d = take;
    data_d  = take ? cell_in : data_q;
    cfg_d   = load ? cfg_nxt : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      cfg_q   <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      cfg_q   <= cfg_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/cell_plane_distributor.sv
module cell_plane_distributor
  import cpd_pkg::*;
#(
  parameter int unsigned NPLANES = CPD_DEF_PLANES,
  parameter int unsigned CELL_W  = CPD_DEF_CELL_W,
  parameter int unsigned CFG_W   = CPD_DEF_CFG_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cell_tick,
  input  logic                      cell_valid,
  input  logic [CELL_W-1:0]         cell_data,
  output logic                      cell_ready,
  input  logic [NPLANES-1:0]        plane_ready,
  output logic [NPLANES-1:0]        plane_valid,
  output logic [NPLANES*CELL_W-1:0] plane_data,
  input  logic [NPLANES*CFG_W-1:0]  sched_cfg_in,
  output logic [NPLANES-1:0]        sched_load,
  output logic [NPLANES*CFG_W-1:0]  sched_cfg
);
  localparam int unsigned IW = cpd_idx_w(NPLANES);

  logic [IW-1:0] rr_q;
  logic [IW-1:0] slot_q;
  logic          accept;

  assign cell_ready = plane_ready[rr_q];
  assign accept     = cell_valid && cell_ready;

  cpd_mod_counter #(.LIMIT(NPLANES), .W(IW)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (accept),
    .count (rr_q)
  );

  cpd_mod_counter #(.LIMIT(NPLANES), .W(IW)) u_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (cell_tick),
    .count (slot_q)
  );

  for (genvar g = 0; g < NPLANES; g++) begin : g_lane
    logic take_g;
    assign take_g        = accept && (rr_q == IW'(g));
    assign sched_load[g] = cell_tick && (slot_q == IW'(g));

    cpd_plane_lane #(.CELL_W(CELL_W), .CFG_W(CFG_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take_g),
      .cell_in (cell_data),
      .load    (sched_load[g]),
      .cfg_nxt (sched_cfg_in[g*CFG_W +: CFG_W]),
      .valid_o (plane_valid[g]),
      .data_o  (plane_data[g*CELL_W +: CELL_W]),
      .cfg_o   (sched_cfg[g*CFG_W +: CFG_W])
    );
  end
endmodule

// File: rtl/cpd_checker.sv
module cpd_checker #(
  parameter int unsigned K   = 4,
  parameter int unsigned CFW = 16,
  parameter int unsigned IW  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cell_tick,
  input logic               cell_valid,
  input logic               cell_ready,
  input logic [K-1:0]       plane_valid,
  input logic [K*CFW-1:0]   sched_cfg_in,
  input logic [K-1:0]       sched_load,
  input logic [K*CFW-1:0]   sched_cfg,
  input logic [IW-1:0]      rr_q
);
  localparam logic [IW-1:0] LAST = IW'(K - 1);

  p_single_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(plane_valid));

  p_deliver_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_ready) |=> ($countones(plane_valid) == 1));

  p_rotate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_ready) |=>
      (rr_q == (($past(rr_q) == LAST) ? '0 : $past(rr_q) + 1'b1)));

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cell_valid && cell_ready) |=> (plane_valid == '0) && $stable(rr_q));

  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sched_load) && ((sched_load != '0) -> cell_tick));

  for (genvar g = 0; g < K; g++) begin : g_cfg
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sched_load[g] |=> (sched_cfg[g*CFW +: CFW] == $past(sched_cfg_in[g*CFW +: CFW])));
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !sched_load[g] |=> $stable(sched_cfg[g*CFW +: CFW]));
  end
endmodule

bind cell_plane_distributor cpd_checker #(.K(NPLANES), .CFW(CFG_W), .IW(IW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cell_tick    (cell_tick),
  .cell_valid   (cell_valid),
  .cell_ready   (cell_ready),
  .plane_valid  (plane_valid),
  .sched_cfg_in (sched_cfg_in),
  .sched_load   (sched_load),
  .sched_cfg    (sched_cfg),
  .rr_q         (rr_q)
);

// File: tb/tb_cell_plane_distributor.sv
module tb_cell_plane_distributor;
  localparam int K   = 4;
  localparam int CW  = 32;
  localparam int CFW = 16;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cell_tick;
  logic              cell_valid;
  logic [CW-1:0]     cell_data;
  logic              cell_ready;
  logic [K-1:0]      plane_ready;
  logic [K-1:0]      plane_valid;
  logic [K*CW-1:0]   plane_data;
  logic [K*CFW-1:0]  sched_cfg_in;
  logic [K-1:0]      sched_load;
  logic [K*CFW-1:0]  sched_cfg;

  int checks = 0;
  int fails  = 0;
  int bptr   = 0;
  int bslot  = 0;
  logic [CFW-1:0] exp_cfg [K];
  logic [CW+7:0]  sb_q [$];

  always #5 clk = ~clk;

  cell_plane_distributor #(.NPLANES(K), .CELL_W(CW), .CFG_W(CFW)) dut (
    .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick), .cell_valid(cell_valid),
    .cell_data(cell_data), .cell_ready(cell_ready), .plane_ready(plane_ready),
    .plane_valid(plane_valid), .plane_data(plane_data), .sched_cfg_in(sched_cfg_in),
    .sched_load(sched_load), .sched_cfg(sched_cfg)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each delivery (R2, R3)
  always @(negedge clk) begin
    if (rst_n) begin
      chk($countones(plane_valid) <= 1, "R2 one plane", 64'(plane_valid), 64'h1);
      for (int p = 0; p < K; p++) begin
        if (plane_valid[p]) begin
          if (sb_q.size() == 0) begin
            chk(1'b0, "R4 unexpected delivery", 64'(p), 64'hFF);
          end else begin
            logic [CW+7:0] e;
            e = sb_q.pop_front();
            chk(p == int'(e[CW+7:CW]), "R3 plane order", 64'(p), 64'(e[CW+7:CW]));
            chk(plane_data[p*CW +: CW] == e[CW-1:0], "R2 data", 64'(plane_data[p*CW +: CW]), 64'(e[CW-1:0]));
          end
        end
      end
    end
  end

  task automatic send(input logic [CW-1:0] d);
    @(negedge clk);
    while (!cell_ready) @(negedge clk);
    cell_valid = 1'b1;
    cell_data  = d;
    sb_q.push_back({8'(bptr), d});
    bptr = (bptr + 1) % K;
    @(negedge clk);
    cell_valid = 1'b0;
  endtask

  task automatic tick_once(input int tag);
    @(negedge clk);
    for (int p = 0; p < K; p++) sched_cfg_in[p*CFW +: CFW] = CFW'(16'h1000 * (p + 1) + tag);
    cell_tick = 1'b1;
    #1;
    chk(sched_load == K'(1 << bslot), "R6 R5 load strobe slot", 64'(sched_load), 64'(1 << bslot));
    exp_cfg[bslot] = sched_cfg_in[bslot*CFW +: CFW];
    @(negedge clk);
    cell_tick = 1'b0;
    for (int p = 0; p < K; p++)
      chk(sched_cfg[p*CFW +: CFW] == exp_cfg[p], "R7 held config", 64'(sched_cfg[p*CFW +: CFW]), 64'(exp_cfg[p]));
    bslot = (bslot + 1) % K;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cell_tick = 1'b0; cell_valid = 1'b0; cell_data = '0;
    plane_ready = '1; sched_cfg_in = '0;
    for (int p = 0; p < K; p++) exp_cfg[p] = '0;
    repeat (3) @(negedge clk);
    chk(plane_valid == '0, "R1 reset valid", 64'(plane_valid), 64'h0);
    chk(sched_cfg == '0, "R1 reset idle config", 64'(sched_cfg), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cell_ready == 1'b1, "R1 ready after reset", 64'(cell_ready), 64'h1);

    // round-robin with several data patterns (R2, R3)
    for (int i = 0; i < 6; i++) send(CW'(32'hC0DE_0000 + i * 32'h0101_0001));
    send('0);
    send('1);

    // stall: target plane not ready, others ready (R4)
    @(negedge clk);
    plane_ready = '1;
    plane_ready[bptr] = 1'b0;
    cell_valid = 1'b1;
    cell_data  = 32'h5A5A_A5A5;
    for (int c = 0; c < 3; c++) begin
      #1;
      chk(cell_ready == 1'b0, "R4 ready follows target", 64'(cell_ready), 64'h0);
      @(negedge clk);
      chk(plane_valid == '0, "R4 no delivery in stall", 64'(plane_valid), 64'h0);
    end
    plane_ready = '1;
    sb_q.push_back({8'(bptr), 32'h5A5A_A5A5});
    bptr = (bptr + 1) % K;
    @(negedge clk);
    cell_valid = 1'b0;
    send(32'h1234_5678);

    // staggered configuration loads over more than one frame (R5, R6, R7)
    for (int t = 0; t < K + 2; t++) tick_once(t);

    // cfg_in changes without a tick are ignored (R8)
    @(negedge clk);
    sched_cfg_in = {K{16'hDEAD}};
    repeat (3) @(negedge clk);
    for (int p = 0; p < K; p++)
      chk(sched_cfg[p*CFW +: CFW] == exp_cfg[p], "R8 no load without strobe", 64'(sched_cfg[p*CFW +: CFW]), 64'(exp_cfg[p]));
    chk(sched_load == '0, "R6 no strobe without tick", 64'(sched_load), 64'h0);

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R2 all cells delivered", 64'(sb_q.size()), 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule